// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing side of a three-channel interval timer. A processor reaches it through an 8-bit data bus with a chip select, a read strobe, a write strobe and a two-bit register address. Three of the four addresses reach the count registers of the three channels. The fourth takes command bytes. A command either configures a channel or freezes a channel's present count so that software can read it. The counting engines sit outside this block. It gives each of them a mode, a decimal/binary flag, a configure pulse, a load pulse with a 16-bit starting value, and a capture pulse. It takes each channel's live 16-bit count as an input.

All bus strobes are sampled on the rising edge of `clk`, and each cycle in which a strobe is high counts as one access. Read data is combinational from the present address and state. The byte-order state that a read moves forward advances at the edge that ends the read cycle.

Top module: `tmr_bus_if`

## Requirements
- R1: After reset, every channel reports mode 0, binary counting, and the two-byte access order, with both byte pointers on the low byte. No configure, load or capture pulse is high.
- R2: When `cs` is low, nothing happens on a write or a read. No pulse is raised, no configuration changes, and no byte pointer moves.
- R3: A write to address 3 with access field bits 5:4 not equal to 00 is a configure command. It is decoded as channel = bits 7:6, access = bits 5:4 (01 low byte only, 10 high byte only, 11 low then high), mode = bits 3:1 and decimal = bit 0. Channel code 3 is ignored. On the next cycle the channel's mode and decimal outputs hold the new values and its configure pulse is high for one cycle. Mode codes 6 and 7 are reported as 2 and 3.
- R4: In low-only access, a write to a channel's address produces a one-cycle load pulse on the next cycle with value {8'h00, byte}. In high-only access the value is {byte, 8'h00}.
- R5: In two-byte access, the first write only stores the byte. The second write produces one load pulse with value {second, first}.
- R6: A configure command returns the channel's write and read byte pointers to the low byte.
- R7: A write to address 3 with bits 5:4 = 00 is a capture command for the channel in bits 7:6. It copies that channel's count as it is at that edge and raises a one-cycle capture pulse. Later reads return the copied bytes while the live count keeps changing.
- R8: A capture is held until the last byte of the access order has been read (one read in single-byte access, the high-byte read in two-byte access). A capture command given while a capture is held raises no pulse and leaves the copy as it is.
- R9: With no capture held, reading a channel returns the byte of its live count chosen by the access order and the read pointer.
- R10: Each channel's read pointer and write pointer are separate, so reads and writes of one channel may alternate without affecting each other.
- R11: Reading address 3 returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address: 0 to 2 are the channels, 3 is the command register |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte |
| chCount | input | 48 | Live count of each channel, channel i at bits 16i+15:16i |
| chMode | output | 9 | Mode of each channel, 3 bits per channel |
| chBcd | output | 3 | Decimal counting flag of each channel |
| chCfgStb | output | 3 | One-cycle configure pulse per channel |
| chLoadStb | output | 3 | One-cycle load pulse per channel |
| chLoadVal | output | 48 | Load value of each channel, 16 bits per channel |
| chLatchReq | output | 3 | One-cycle capture pulse per channel |

## Verification
Two things can fall into the same cycle. One is a capture command. The other is a change of the live count it copies. The bench drives one channel's count downward on every edge and issues the capture in the middle of that. It records the count that was on the input during the cycle of the command, and it expects both read bytes to equal that value even though the live input has moved on by the time they are read. A second capture issued between the two reads must leave the copy as it is. The read after the high byte must then follow the live count again.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CMD_ADDR = 2'd3;

  typedef enum logic [1:0] {
    ACC_CAPTURE = 2'b00,
    ACC_LOW     = 2'b01,
    ACC_HIGH    = 2'b10,
    ACC_PAIR    = 2'b11
  } access_e;

  // one cycle worth of decoded bus activity
  typedef struct packed {
    logic              cfgWr;
    logic              latchCmd;
    logic              cntWr;
    logic              cntRd;
    logic [ADDR_W-1:0] regSel;
    logic [ADDR_W-1:0] chan;
    access_e           access;
    logic [MODE_W-1:0] mode;
    logic              bcd;
    logic [BYTE_W-1:0] data;
  } bus_strobe_t;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_bus_pkg::*;
(
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output bus_strobe_t       st
);
  logic cmdHit;
  logic isCapture;

  assign cmdHit = (addr == CMD_ADDR);
  assign isCapture = (wrData[5:4] == 2'b00);

  always_comb begin
    st.regSel = addr;
    st.data = wrData;
    st.access = access_e'(wrData[5:4]);
    st.bcd = wrData[0];
    // codes 6 and 7 fold onto 2 and 3
    st.mode = (wrData[3:2] == 2'b11) ? {1'b0, wrData[2:1]} : wrData[3:1];
    st.chan = cmdHit ? wrData[7:6] : addr;
    st.cfgWr = cs && wr && cmdHit && !isCapture;
    st.latchCmd = cs && wr && cmdHit && isCapture;
    st.cntWr = cs && wr && !cmdHit;
    st.cntRd = cs && rd && !wr && !cmdHit;
  end
endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs
  import tmr_bus_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bus_strobe_t              st,
  input  logic [NUM_CH*CNT_W-1:0]  chCount,
  output logic [BYTE_W-1:0]        rdData,
  output logic [NUM_CH*MODE_W-1:0] chMode,
  output logic [NUM_CH-1:0]        chBcd,
  output logic [NUM_CH-1:0]        chCfgStb,
  output logic [NUM_CH-1:0]        chLoadStb,
  output logic [NUM_CH*CNT_W-1:0]  chLoadVal,
  output logic [NUM_CH-1:0]        chLatchReq
);
  localparam int SLOTS = 1 << ADDR_W;

  logic [BYTE_W-1:0] rdByte [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_CH) begin : g_ch
      logic              hit;
      logic [MODE_W-1:0] modeQ;
      logic              bcdQ;
      access_e           accQ;
      logic              wrHiQ;
      logic              rdHiQ;
      logic [BYTE_W-1:0] lowHoldQ;
      logic [CNT_W-1:0]  snapQ;
      logic              heldQ;
      logic              cfgQ;
      logic              loadQ;
      logic              capQ;
      logic [CNT_W-1:0]  loadValQ;
      logic [CNT_W-1:0]  rdSrc;
      logic              rdHiSel;

      assign hit = (st.chan == ADDR_W'(i));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          modeQ <= '0;
          bcdQ <= 1'b0;
          accQ <= ACC_PAIR;
          wrHiQ <= 1'b0;
          rdHiQ <= 1'b0;
          lowHoldQ <= '0;
          snapQ <= '0;
          heldQ <= 1'b0;
          cfgQ <= 1'b0;
          loadQ <= 1'b0;
          capQ <= 1'b0;
          loadValQ <= '0;
        end else begin
          cfgQ <= 1'b0;
          loadQ <= 1'b0;
          capQ <= 1'b0;
          if (st.cfgWr && hit) begin
            modeQ <= st.mode;
            bcdQ <= st.bcd;
            accQ <= st.access;
            wrHiQ <= 1'b0;
            rdHiQ <= 1'b0;
            heldQ <= 1'b0;
            cfgQ <= 1'b1;
          end else if (st.latchCmd && hit && !heldQ) begin
            snapQ <= chCount[i*CNT_W +: CNT_W];
            heldQ <= 1'b1;
            capQ <= 1'b1;
          end
          if (st.cntWr && hit) begin
            unique case (accQ)
              ACC_LOW: begin
                loadValQ <= {{BYTE_W{1'b0}}, st.data};
                loadQ <= 1'b1;
              end
              ACC_HIGH: begin
                loadValQ <= {st.data, {BYTE_W{1'b0}}};
                loadQ <= 1'b1;
              end
              default: begin
                if (!wrHiQ) begin
                  lowHoldQ <= st.data;
                  wrHiQ <= 1'b1;
                end else begin
                  loadValQ <= {st.data, lowHoldQ};
                  loadQ <= 1'b1;
                  wrHiQ <= 1'b0;
                end
              end
            endcase
          end
          if (st.cntRd && hit) begin
            if (accQ == ACC_PAIR) begin
              rdHiQ <= !rdHiQ;
              if (rdHiQ) heldQ <= 1'b0;
            end else begin
              heldQ <= 1'b0;
            end
          end
        end
      end

      assign rdSrc = heldQ ? snapQ : chCount[i*CNT_W +: CNT_W];
      assign rdHiSel = (accQ == ACC_HIGH) || ((accQ == ACC_PAIR) && rdHiQ);
      assign rdByte[i] = rdHiSel ? rdSrc[CNT_W-1 -: BYTE_W] : rdSrc[BYTE_W-1:0];

      assign chMode[i*MODE_W +: MODE_W] = modeQ;
      assign chBcd[i] = bcdQ;
      assign chCfgStb[i] = cfgQ;
      assign chLoadStb[i] = loadQ;
      assign chLoadVal[i*CNT_W +: CNT_W] = loadValQ;
      assign chLatchReq[i] = capQ;
    end else begin : g_none
      assign rdByte[i] = '0;
    end
  end

  assign rdData = rdByte[st.regSel];
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_bus_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cs,
  input  logic                     rd,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W-1:0]        wrData,
  output logic [BYTE_W-1:0]        rdData,
  input  logic [NUM_CH*CNT_W-1:0]  chCount,
  output logic [NUM_CH*MODE_W-1:0] chMode,
  output logic [NUM_CH-1:0]        chBcd,
  output logic [NUM_CH-1:0]        chCfgStb,
  output logic [NUM_CH-1:0]        chLoadStb,
  output logic [NUM_CH*CNT_W-1:0]  chLoadVal,
  output logic [NUM_CH-1:0]        chLatchReq
);
  bus_strobe_t st;

  tmr_bus_decode u_decode (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wrData(wrData), .st(st)
  );

  tmr_bus_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rstN(rstN), .st(st), .chCount(chCount), .rdData(rdData),
    .chMode(chMode), .chBcd(chBcd), .chCfgStb(chCfgStb),
    .chLoadStb(chLoadStb), .chLoadVal(chLoadVal), .chLatchReq(chLatchReq)
  );
endmodule

// File: rtl/tmr_bus_if_chk.sv
module tmr_bus_if_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cs,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [3:0]        ctlSel,
  input logic [NUM_CH-1:0] chCfgStb,
  input logic [NUM_CH-1:0] chLoadStb,
  input logic [NUM_CH-1:0] chLatchReq
);
  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cs) |-> (chCfgStb == '0 && chLoadStb == '0 && chLatchReq == '0));

  // R3
  cfg_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chCfgStb) |-> $past(cs && wr && addr == 2'd3 && ctlSel[1:0] != 2'b00));

  // R4
  load_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chLoadStb) |-> $past(cs && wr && addr != 2'd3));

  // R7
  capture_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chLatchReq) |-> $past(cs && wr && addr == 2'd3 && ctlSel[1:0] == 2'b00));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R3
    cfg_target_chk: assert property (@(posedge clk) disable iff (!rstN)
      chCfgStb[i] |-> ($past(ctlSel[3:2]) == 2'(i)));
  end
endmodule

bind tmr_bus_if tmr_bus_if_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .wr(wr), .addr(addr),
  .ctlSel(wrData[7:4]), .chCfgStb(chCfgStb), .chLoadStb(chLoadStb),
  .chLatchReq(chLatchReq)
);

// File: tb/tmr_bus_if_test.sv
module tmr_bus_if_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] cnt0 = 16'hBEEF, cnt1 = 16'h8000, cnt2 = 16'h4321;
  logic [47:0] chCount;
  logic [8:0]  chMode;
  logic [2:0]  chBcd, chCfgStb, chLoadStb, chLatchReq;
  logic [47:0] chLoadVal;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [19:0] expQ[$];

  localparam logic [1:0] K_CFG = 2'd1, K_LOAD = 2'd2, K_CAP = 2'd3;

  assign chCount = {cnt2, cnt1, cnt0};

  always #5 clk = ~clk;
  always @(posedge clk) cnt1 <= cnt1 - 16'd1;

  tmr_bus_if uut (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wrData(wrData), .rdData(rdData), .chCount(chCount), .chMode(chMode),
    .chBcd(chBcd), .chCfgStb(chCfgStb), .chLoadStb(chLoadStb),
    .chLoadVal(chLoadVal), .chLatchReq(chLatchReq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] kind, input logic [1:0] ch, input logic [15:0] val);
    expQ.push_back({kind, ch, val});
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input bit sel = 1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic busCapture(input logic [7:0] d, input int ch, output logic [15:0] snap);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = 2'd3; wrData = d;
    snap = chCount[ch*16 +: 16];
    push(K_CAP, 2'(ch), 16'h0000);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, input logic [7:0] exp, input string tag,
                         input bit sel = 1, input bit liveCh1 = 0);
    @(negedge clk);
    cs = sel; rd = 1'b1; addr = a;
    #1;
    if (sel) check(tag, {8'h00, rdData}, {8'h00, liveCh1 ? cnt1[7:0] : exp});
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  // scoreboard monitor: every pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 3; i++) begin
        logic [1:0] k;
        k = chCfgStb[i] ? K_CFG : chLoadStb[i] ? K_LOAD : chLatchReq[i] ? K_CAP : 2'd0;
        if (k != 2'd0) begin
          logic [19:0] got, want;
          got = {k, 2'(i), (k == K_LOAD) ? chLoadVal[i*16 +: 16] : 16'h0000};
          total++;
          if (expQ.size() == 0) begin
            bad++;
            $display("FAIL R2 unexpected pulse actual=%h expected=none", got);
          end else begin
            want = expQ.pop_front();
            if (got !== want) begin
              bad++;
              $display("FAIL %s pulse actual=%h expected=%h",
                       (want[19:18] == K_LOAD) ? "R4" : (want[19:18] == K_CFG) ? "R3" : "R7",
                       got, want);
            end
          end
        end
      end
    end
  end

  initial begin
    logic [15:0] snap1, snap2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", {7'd0, chMode}, 16'h0000);
    check("R1 bcd", {13'd0, chBcd}, 16'h0000);
    check("R1 pulses", {7'd0, chCfgStb, chLoadStb, chLatchReq}, 16'h0000);

    // R2 writes with chip select low
    busWrite(2'd3, 8'h3F, 0);
    busWrite(2'd0, 8'h55, 0);
    check("R2 mode after deselected write", {7'd0, chMode}, 16'h0000);

    // R3 configure ch0: pair access, mode 2, decimal
    push(K_CFG, 2'd0, 16'h0000);
    busWrite(2'd3, 8'h35);
    check("R3 ch0 mode", {13'd0, chMode[2:0]}, 16'd2);
    check("R3 ch0 bcd", {15'd0, chBcd[0]}, 16'd1);

    // R3 mode code 7 folds to 3; R4 low-only load
    push(K_CFG, 2'd2, 16'h0000);
    busWrite(2'd3, 8'h9E);
    check("R3 ch2 mode fold", {13'd0, chMode[8:6]}, 16'd3);
    push(K_LOAD, 2'd2, 16'h005A);
    busWrite(2'd2, 8'h5A);

    // R4 high-only load on ch1
    push(K_CFG, 2'd1, 16'h0000);
    busWrite(2'd3, 8'h60);
    push(K_LOAD, 2'd1, 16'h1200);
    busWrite(2'd1, 8'h12);

    // R5 two-byte load on ch0
    busWrite(2'd0, 8'h34);
    push(K_LOAD, 2'd0, 16'h1234);
    busWrite(2'd0, 8'h12);

    // R6 configure resets the write pointer mid-pair
    busWrite(2'd0, 8'h77);
    push(K_CFG, 2'd0, 16'h0000);
    busWrite(2'd3, 8'h35);
    busWrite(2'd0, 8'hAA);
    push(K_LOAD, 2'd0, 16'hBBAA);
    busWrite(2'd0, 8'hBB);

    // R9 live reads; a deselected read must not move the pointer (R2)
    busRead(2'd0, 8'h00, "R2", 0);
    busRead(2'd0, 8'hEF, "R9 live low");
    busRead(2'd0, 8'hBE, "R9 live high");

    // R7 capture of a moving count, R8 second capture ignored
    push(K_CFG, 2'd1, 16'h0000);
    busWrite(2'd3, 8'h70);
    busCapture(8'h40, 1, snap1);
    repeat (4) @(negedge clk);
    busRead(2'd1, snap1[7:0], "R7 captured low");
    busWrite(2'd3, 8'h40);
    busRead(2'd1, snap1[15:8], "R8 captured high after second capture");
    busRead(2'd1, 8'h00, "R8 released to live", 1, 1);

    // R8 single-byte access releases after one read
    busCapture(8'h80, 2, snap2);
    @(negedge clk);
    cnt2 = 16'h9999;
    busRead(2'd2, snap2[7:0], "R8 single captured");
    busRead(2'd2, 8'h99, "R8 single released");

    // R10 interleaved reads and writes of ch0
    busWrite(2'd0, 8'h11);
    busRead(2'd0, 8'hEF, "R10 read low between writes");
    push(K_LOAD, 2'd0, 16'h2211);
    busWrite(2'd0, 8'h22);
    busRead(2'd0, 8'hBE, "R10 read high after load");

    // R11 command address read; R3 channel code 3 ignored
    busRead(2'd3, 8'h00, "R11 command read");
    busWrite(2'd3, 8'hFE);
    check("R3 channel 3 ignored", {7'd0, chMode}, {7'd0, 3'd3, 3'd0, 3'd2});

    repeat (4) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R4 missing pulses actual=%0d expected=0", expQ.size());
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule